// File: doc/BRIEF.md
# NOR-and-branch one-instruction processor

This block is a small multi-cycle processor with exactly one instruction. Every instruction is four bytes long and holds only addresses: two operand locations and two possible successor locations. The core reads the two operand bytes, forms their bitwise NOR, stores that result over the second operand, and then jumps to one of the two successor addresses. The zero test on the result picks which one. There is no opcode and no program counter increment. Arbitrary computation is built from sequences of these NOR-and-fork steps.

Program and data live together in one 256-byte single-port synchronous RAM inside the block, so a program may rewrite its own instructions. While synchronous reset is held, a host port can write and read any byte of that memory. This is used to load a program and, later, to inspect its results. When reset is released, the core starts at address 0. It stops, raising a halted flag, on an instruction whose two successor fields both point back at that instruction.

Top module: `norfork_core`

## Requirements
- R1: An instruction at address I occupies bytes I, I+1, I+2 and I+3: first operand address at I+0, second operand address at I+1, nonzero-result successor at I+2, zero-result successor at I+3.
- R2: The result of an instruction is the bitwise NOR of the byte at the first operand address and the byte at the second operand address, including the case where both addresses are the same.
- R3: The result is written to the second operand address and to no other byte.
- R4: When the result equals 0x00 the next instruction starts at the I+3 successor; otherwise it starts at the I+2 successor.
- R5: The next instruction address comes only from a successor field; no address is ever formed by incrementing past the current instruction.
- R6: The first instruction after reset is released is the one at address 0.
- R7: When both successor fields of an executed instruction equal its own address I, that instruction still performs its write, then `halted` goes high and stays high with no further memory writes until reset. A single self-pointing successor does not halt.
- R8: While `rst` is high, a host write with `hostWe` high stores `hostWrData` at `hostAddr` on the clock edge, and `hostRdData` shows the byte at the `hostAddr` sampled at the previous edge.
- R9: While `rst` is low, `hostWe`, `hostAddr` and `hostWrData` have no effect on memory.
- R10: The result write of one instruction lands before the next instruction's bytes are fetched, so a write into a later instruction's field changes that instruction. Fields of the current instruction that were already fetched are not fetched again.
- R11: Each instruction takes exactly 8 clock cycles. The first starts in the cycle right after reset is released. If the halting instruction starts in cycle c, `halted` is high from cycle c+8.
- R12: Reset is synchronous and brings `halted` low by the edge on which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the host port |
| hostWe | input | 1 | Host write strobe, used only during reset |
| hostAddr | input | 8 | Host memory address |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Registered memory read data (host view) |
| halted | output | 1 | High once a self-looping instruction has executed |

## Verification
Two things can happen in the same cycle. One is the result write of an instruction. The other is the fetching of the next instruction, or a host write arriving while the core is running. A self-modifying program is used to provoke the first case: one instruction rewrites the zero-successor field of the next instruction, so control ends up at a halting instruction only if the write landed before the fetch, and otherwise loops forever. A host write aimed at an untouched data byte is driven in the middle of a run to provoke the second case. A behavioural reference, working one instruction at a time, predicts the halted flag on every clock and the final contents of all 256 bytes. The bench reads those bytes back through the host port and compares them.

// File: rtl/norfork_pkg.sv
package norfork_pkg;

  typedef enum logic [3:0] {
    ST_F0   = 4'd0,
    ST_F1   = 4'd1,
    ST_F2   = 4'd2,
    ST_F3   = 4'd3,
    ST_RDA  = 4'd4,
    ST_RDB  = 4'd5,
    ST_WR   = 4'd6,
    ST_NX   = 4'd7,
    ST_HALT = 4'd8
  } coreState_e;

  typedef enum logic [1:0] {
    SEL_PC = 2'd0,
    SEL_A  = 2'd1,
    SEL_B  = 2'd2
  } addrSel_e;

  typedef struct packed {
    addrSel_e   addrSel;
    logic [1:0] fieldOfs;
    logic       ldAAddr;
    logic       ldBAddr;
    logic       ldTgtNz;
    logic       ldTgtZ;
    logic       ldValA;
    logic       ldZero;
    logic       memWe;
    logic       ldPc;
  } ctlStrobe_t;

endpackage

// File: rtl/nf_ram.sv
module nf_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wrData;
    end
    rdData <= store[addr];
  end

endmodule

// File: rtl/nf_datapath.sv
module nf_datapath
  import norfork_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              selfLoop
);
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] aAddr;
  logic [ADDR_W-1:0] bAddr;
  logic [ADDR_W-1:0] tgtNz;
  logic [ADDR_W-1:0] tgtZ;
  logic [DATA_W-1:0] valA;
  logic              zeroFlag;
  logic [ADDR_W-1:0] nextPc;

  always_comb begin
    unique case (strobe.addrSel)
      SEL_A:   memAddr = aAddr;
      SEL_B:   memAddr = bAddr;
      default: memAddr = pc + ADDR_W'(strobe.fieldOfs);
    endcase
  end

  assign wrData   = ~(valA | rdData);
  assign selfLoop = (tgtNz == pc) && (tgtZ == pc);
  assign nextPc   = zeroFlag ? tgtZ : tgtNz;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      aAddr    <= '0;
      bAddr    <= '0;
      tgtNz    <= '0;
      tgtZ     <= '0;
      valA     <= '0;
      zeroFlag <= 1'b0;
    end else begin
      if (strobe.ldAAddr) aAddr    <= ADDR_W'(rdData);
      if (strobe.ldBAddr) bAddr    <= ADDR_W'(rdData);
      if (strobe.ldTgtNz) tgtNz    <= ADDR_W'(rdData);
      if (strobe.ldTgtZ)  tgtZ     <= ADDR_W'(rdData);
      if (strobe.ldValA)  valA     <= rdData;
      if (strobe.ldZero)  zeroFlag <= (wrData == '0);
      if (strobe.ldPc)    pc       <= nextPc;
    end
  end

  AST_PC_FROM_TARGET: assert property (@(posedge clk) disable iff (rst)
    strobe.ldPc |=> (pc == $past(tgtNz) || pc == $past(tgtZ))); // R5

  AST_ZERO_SELECTS_Z: assert property (@(posedge clk) disable iff (rst)
    (strobe.ldPc && zeroFlag) |=> (pc == $past(tgtZ))); // R4

  AST_WRITE_SAME_B: assert property (@(posedge clk) disable iff (rst)
    strobe.memWe |-> (memAddr == bAddr)); // R3

endmodule

// File: rtl/nf_control.sv
module nf_control
  import norfork_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       selfLoop,
  output ctlStrobe_t strobe,
  output logic       halted
);
  coreState_e state;
  coreState_e stateNext;

  always_comb begin
    strobe    = '0;
    strobe.addrSel = SEL_PC;
    stateNext = state;
    unique case (state)
      ST_F0: begin
        strobe.fieldOfs = 2'd0;
        stateNext = ST_F1;
      end
      ST_F1: begin
        strobe.fieldOfs = 2'd1;
        strobe.ldAAddr  = 1'b1;
        stateNext = ST_F2;
      end
      ST_F2: begin
        strobe.fieldOfs = 2'd2;
        strobe.ldBAddr  = 1'b1;
        stateNext = ST_F3;
      end
      ST_F3: begin
        strobe.fieldOfs = 2'd3;
        strobe.ldTgtNz  = 1'b1;
        stateNext = ST_RDA;
      end
      ST_RDA: begin
        strobe.addrSel = SEL_A;
        strobe.ldTgtZ  = 1'b1;
        stateNext = ST_RDB;
      end
      ST_RDB: begin
        strobe.addrSel = SEL_B;
        strobe.ldValA  = 1'b1;
        stateNext = ST_WR;
      end
      ST_WR: begin
        strobe.addrSel = SEL_B;
        strobe.memWe   = 1'b1;
        strobe.ldZero  = 1'b1;
        stateNext = ST_NX;
      end
      ST_NX: begin
        if (selfLoop) begin
          stateNext = ST_HALT;
        end else begin
          strobe.ldPc = 1'b1;
          stateNext = ST_F0;
        end
      end
      default: begin
        stateNext = ST_HALT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_F0;
    end else begin
      state <= stateNext;
    end
  end

  assign halted = (state == ST_HALT);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R7

  AST_ONE_WRITE_PER_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.memWe |=> !strobe.memWe); // R11

  AST_NO_LOAD_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!strobe.ldPc && !strobe.memWe)); // R7

endmodule

// File: rtl/norfork_core.sv
module norfork_core
  import norfork_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              halted
);
  ctlStrobe_t        strobe;
  logic              selfLoop;
  logic [ADDR_W-1:0] coreAddr;
  logic [DATA_W-1:0] coreWrData;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWrData;
  logic [DATA_W-1:0] ramRdData;
  logic              ramWe;

  assign ramAddr    = rst ? hostAddr   : coreAddr;
  assign ramWrData  = rst ? hostWrData : coreWrData;
  assign ramWe      = rst ? hostWe     : strobe.memWe;
  assign hostRdData = ramRdData;

  nf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .we     (ramWe),
    .addr   (ramAddr),
    .wrData (ramWrData),
    .rdData (ramRdData)
  );

  nf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rdData   (ramRdData),
    .memAddr  (coreAddr),
    .wrData   (coreWrData),
    .selfLoop (selfLoop)
  );

  nf_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .selfLoop (selfLoop),
    .strobe   (strobe),
    .halted   (halted)
  );

  AST_WRITE_AFTER_READB: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (ramAddr == $past(ramAddr))); // R3

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ramAddr == '0)); // R6

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ramWe); // R7

endmodule

// File: tb/norfork_core_tb.sv
module norfork_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hostWe = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic       halted;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] img [256];
  logic [7:0] ref_mem [256];
  int         haltIdx;

  always #4 clk = ~clk;

  norfork_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .hostWe     (hostWe),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .halted     (halted)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 8'(a); hostWrData = 8'(d);
    @(posedge clk);
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic host_read(input int a, output int d);
    @(negedge clk);
    hostAddr = 8'(a);
    @(posedge clk);
    @(negedge clk);
    d = int'(hostRdData);
  endtask

  // behavioural reference: one instruction at a time
  task automatic run_model();
    int pc = 0;
    haltIdx = -1;
    for (int i = 0; i < 256; i++) ref_mem[i] = img[i];
    for (int n = 0; n < 2000; n++) begin
      int fa = ref_mem[pc];
      int fb = ref_mem[(pc + 1) % 256];
      int tn = ref_mem[(pc + 2) % 256];
      int tz = ref_mem[(pc + 3) % 256];
      logic [7:0] res = ~(ref_mem[fa] | ref_mem[fb]);
      ref_mem[fb] = res;
      if (tn == pc && tz == pc) begin
        haltIdx = n;
        break;
      end
      pc = (res == 8'h00) ? tz : tn;
    end
  endtask

  task automatic run_prog(input string tag, input bit poke);
    int d;
    rst = 1'b1;
    for (int i = 0; i < 256; i++) host_write(i, img[i]);
    for (int i = 0; i < 256; i += 17) begin
      host_read(i, d);
      check("R8", d, img[i], $sformatf("readback %0d", i));
    end
    run_model();
    check("R7", haltIdx >= 0 ? 1 : 0, 1, {tag, " model halts"});
    @(negedge clk);
    rst = 1'b0;
    for (int e = 1; e <= 8 * (haltIdx + 1) + 4; e++) begin
      @(posedge clk);
      @(negedge clk);
      check("R11", halted, (e >= 8 * (haltIdx + 1)) ? 1 : 0,
            $sformatf("%s halted after edge %0d", tag, e));
      if (poke && e == 5) begin
        hostWe = 1'b1; hostAddr = 8'd200; hostWrData = 8'h77;
      end
      if (poke && e == 6) hostWe = 1'b0;
    end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R12", halted, 0, {tag, " halted cleared by reset"});
    for (int i = 0; i < 256; i++) begin
      host_read(i, d);
      check(tag, d, ref_mem[i], $sformatf("final byte %0d", i));
    end
  endtask

  task automatic put(input int a, input int x, input int y, input int n, input int z);
    img[a] = 8'(x); img[a+1] = 8'(y); img[a+2] = 8'(n); img[a+3] = 8'(z);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    repeat (2) @(negedge clk);
    check("R12", halted, 0, "halted low in reset");

    // single self-looping instruction at address 0
    put(0, 16, 17, 0, 0);
    img[16] = 8'h0F; img[17] = 8'h30;
    run_prog("R1 R2 R3 R6 R7", 1'b0);

    // zero and nonzero forks with no fall-through
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    put(0, 40, 41, 4, 8);
    put(4, 44, 45, 4, 4);
    put(8, 42, 43, 12, 4);
    put(12, 46, 47, 12, 12);
    img[40] = 8'hF0; img[41] = 8'h0F; img[42] = 8'h01; img[43] = 8'h00;
    img[44] = 8'hAA; img[45] = 8'h55;
    run_prog("R4 R5", 1'b0);

    // self-modifying path, one-sided self target, same-address NOR, host poke
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    put(0, 60, 61, 0, 20);
    put(20, 62, 27, 24, 24);
    put(24, 63, 64, 28, 0);
    put(32, 65, 65, 32, 32);
    img[60] = 8'hFF; img[62] = 8'hDF; img[63] = 8'hFF; img[65] = 8'h3C;
    img[200] = 8'h11;
    run_prog("R9 R10 R2", 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule